// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital core of one successive-approximation converter unit. A one-cycle start request begins a ten-step binary search over the input range, most significant bit first. In each step the block places a trial code on the DAC controls. An external comparator then reports whether the sampled input lies below the level of that trial code. The block uses that decision to keep or drop the bit under test.

The trial code goes out on two DAC controls. The five high bits drive the switch controls of a binary-weighted capacitor array directly. The five low bits pass through a decoder that selects exactly one of 32 taps on a resistor string. When the last bit has been decided, the block presents the 10-bit result and a one-cycle completion pulse. The result stays in place until the next conversion completes.

Top module: `sar_conv_seq`

## Requirements
- R1: A synchronous active-high reset clears the trial code, the result, the busy flag and the completion pulse. After reset `capSwitch` reads 0 and `tapSelect` reads 32'h1.
- R2: A start request seen while idle sets busy, and in the next cycle the trial code is 10'h200 (only bit 9 set).
- R3: In each step, the bit under test is cleared when `cmpBelow` is 1 and kept at 1 when `cmpBelow` is 0. The next lower bit is then set to 1, and every bit already decided stays unchanged.
- R4: One conversion takes exactly 10 busy cycles, one decision per cycle.
- R5: `capSwitch` equals bits 9..5 of the trial code, with bit 9 on `capSwitch[4]`.
- R6: `tapSelect` is one-hot at all times, and its set bit is at the index given by bits 4..0 of the trial code.
- R7: `done` is high for exactly one cycle, in the cycle after the last decision. Busy is low while `done` is high. With an ideal comparator, `result` then equals the input code.
- R8: `result` changes only when a conversion completes.
- R9: A start request that arrives while busy is ignored: it neither restarts the search nor changes its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startPulse | input | 1 | Conversion start request |
| cmpBelow | input | 1 | Comparator decision: input is below the trial level |
| capSwitch | output | 5 | Capacitor-array switch controls (trial code bits 9..5) |
| tapSelect | output | 32 | One-hot resistor-string tap select (decoded trial code bits 4..0) |
| result | output | 10 | Last completed conversion result |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Conversion in progress |

## Verification
Some properties are checked on every cycle by assertions:
- the step counter moves down by one per busy cycle;
- the trial code falls after a "below" decision and rises after a "keep" decision;
- the resistor tap select stays one-hot;
- the completion pulse lasts one cycle while busy is low;
- the result holds between completions.

Other behaviour shows only in the bench's scenarios:
- that the final code equals the input for boundary and mid-range values;
- the exact trial code sequence at the ports;
- that a start request during a conversion leaves its result and timing unchanged;
- that a reset mid-conversion clears everything.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } sarStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES_BITS = 10,
  localparam int IDXW = $clog2(RES_BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            startPulse,
  output sarStrobe_t      strobe,
  output logic [IDXW-1:0] bitIdx,
  output logic            busy,
  output logic            done
);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(RES_BITS - 1);

  always_comb begin
    strobe.load = !busy && startPulse;
    strobe.step = busy;
    strobe.last = busy && (bitIdx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      bitIdx <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobe.load) begin
        busy   <= 1'b1;
        bitIdx <= TOP_IDX;
      end else if (busy) begin
        if (bitIdx == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bitIdx <= bitIdx - 1'b1;
        end
      end
    end
  end

  // R4: one decision per busy cycle, counting down
  assert_idx_down_R4: assert property (@(posedge clk) disable iff (rst)
    busy && bitIdx != '0 |=> busy && bitIdx == IDXW'($past(bitIdx) - 1'b1));
  // R7: completion pulse is a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: completion only when idle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: start while busy does not reload the step counter
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    busy && startPulse && bitIdx != '0 |=> bitIdx != TOP_IDX);
endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_pkg::*;
#(
  parameter int RES_BITS = 10,
  localparam int IDXW = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  sarStrobe_t          strobe,
  input  logic [IDXW-1:0]     bitIdx,
  input  logic                cmpBelow,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] result
);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] nextCode;

  always_comb begin
    nextCode = trialCode;
    nextCode[bitIdx] = !cmpBelow;
    if (bitIdx != '0) nextCode[IDXW'(bitIdx - 1'b1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trialCode <= '0;
      result    <= '0;
    end else if (strobe.load) begin
      trialCode <= MSB_ONLY;
    end else if (strobe.step) begin
      trialCode <= nextCode;
      if (strobe.last) result <= nextCode;
    end
  end

  // R2: a new search starts from mid-scale
  assert_load_msb_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> trialCode == MSB_ONLY);
  // R3: a "below" decision lowers the trial level
  assert_below_drops_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.step && cmpBelow |=> trialCode < $past(trialCode));
  // R3: a "keep" decision raises the trial level (except on the last bit)
  assert_keep_rises_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.step && !cmpBelow && !strobe.last |=> trialCode > $past(trialCode));
  // R8: result holds between completions
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.last |=> $stable(result));
endmodule

// File: rtl/sar_tap_decode.sv
module sar_tap_decode #(
  parameter int SEL_BITS = 5,
  localparam int TAPS = 1 << SEL_BITS
) (
  input  logic [SEL_BITS-1:0] sel,
  output logic [TAPS-1:0]     tapSel
);
  for (genvar i = 0; i < TAPS; i++) begin : gTap
    assign tapSel[i] = (sel == SEL_BITS'(i));
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int CAP_BITS = 5,
  localparam int TAP_BITS = RES_BITS - CAP_BITS,
  localparam int TAPS = 1 << TAP_BITS,
  localparam int IDXW = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startPulse,
  input  logic                cmpBelow,
  output logic [CAP_BITS-1:0] capSwitch,
  output logic [TAPS-1:0]     tapSelect,
  output logic [RES_BITS-1:0] result,
  output logic                done,
  output logic                busy
);
  sarStrobe_t          strobe;
  logic [IDXW-1:0]     bitIdx;
  logic [RES_BITS-1:0] trialCode;

  sar_ctrl #(.RES_BITS(RES_BITS)) uCtrl (
    .clk(clk), .rst(rst), .startPulse(startPulse),
    .strobe(strobe), .bitIdx(bitIdx), .busy(busy), .done(done)
  );

  sar_dpath #(.RES_BITS(RES_BITS)) uDpath (
    .clk(clk), .rst(rst), .strobe(strobe), .bitIdx(bitIdx),
    .cmpBelow(cmpBelow), .trialCode(trialCode), .result(result)
  );

  assign capSwitch = trialCode[RES_BITS-1:TAP_BITS];

  sar_tap_decode #(.SEL_BITS(TAP_BITS)) uTap (
    .sel(trialCode[TAP_BITS-1:0]), .tapSel(tapSelect)
  );

  // R6: exactly one resistor tap is selected
  assert_tap_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(tapSelect) == 1);
endmodule

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startPulse = 1'b0;
  logic cmpBelow;
  logic [4:0]  capSwitch;
  logic [31:0] tapSelect;
  logic [9:0]  result;
  logic done, busy;
  logic [9:0] vin = '0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sar_conv_seq u0 (
    .clk(clk), .rst(rst), .startPulse(startPulse), .cmpBelow(cmpBelow),
    .capSwitch(capSwitch), .tapSelect(tapSelect), .result(result),
    .done(done), .busy(busy)
  );

  function automatic int tapIndex(input logic [31:0] t);
    int idx = -1;
    for (int i = 0; i < 32; i++) if (t[i]) idx = i;
    return idx;
  endfunction

  function automatic logic [9:0] portCode();
    return {capSwitch, 5'(tapIndex(tapSelect))};
  endfunction

  // behavioural comparator built from the DAC controls at the ports
  assign cmpBelow = (vin < portCode());

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1; startPulse = 1'b0;
    @(negedge clk) rst = 1'b0;
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(result == '0, "R1 result", result, 0);
    check(capSwitch == '0, "R1 capSwitch", capSwitch, 0);
    check(tapSelect == 32'h1, "R1 tapSelect", tapSelect, 1);
  endtask

  task automatic convert(input logic [9:0] v, input int glitchAt);
    logic [9:0] exp;
    int busyCnt = 0;
    vin = v;
    @(negedge clk) startPulse = 1'b1;
    exp = 10'h200;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      startPulse = (k == glitchAt);
      if (busy) busyCnt++;
      if (k == 1) check(busy && portCode() == 10'h200, "R2 start", portCode(), 10'h200);
      check(portCode() == exp, "R3 trial code", portCode(), exp);
      check(capSwitch == exp[9:5], "R5 capSwitch", capSwitch, exp[9:5]);
      check(tapSelect == (32'h1 << exp[4:0]), "R6 tapSelect", tapIndex(tapSelect), exp[4:0]);
      if (vin < exp) exp[10-k] = 1'b0;
      if (k < 10) exp[9-k] = 1'b1;
    end
    @(negedge clk);
    startPulse = 1'b0;
    check(busyCnt == 10, glitchAt > 0 ? "R9 length" : "R4 length", busyCnt, 10);
    check(done && !busy, "R7 done", done, 1);
    check(result == v, glitchAt > 0 ? "R9 result" : "R7 result", result, v);
    @(negedge clk);
    check(!done, "R7 pulse width", done, 0);
    vin = ~v;
    repeat (3) @(negedge clk);
    check(result == v && !busy, "R8 hold", result, v);
  endtask

  task automatic resetMid();
    vin = 10'd777;
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(!busy && !done, "R1 mid busy", busy, 0);
    check(portCode() == '0 && result == '0, "R1 mid code", portCode(), 0);
    repeat (12) @(negedge clk);
    check(!busy && !done, "R1 stays idle", busy, 0);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset();
    convert(10'd0, 0);
    convert(10'd1023, 0);
    convert(10'd512, 0);
    convert(10'd511, 0);
    convert(10'd341, 0);
    convert(10'd682, 0);
    convert(10'd31, 4);
    convert(10'd600, 9);
    resetMid();
    convert(10'd33, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule